// File: doc/BRIEF.md
# Branch Trace Recorder

The recorder observes control-flow events reported by a processor core. Each event carries a source address, a target address and a two-bit kind. Taken branches, interrupts and exceptions produce a record, and not-taken branches produce nothing. A nine-bit control register selects what happens to each record. It can be pushed onto a small circular stack of the most recent transfers. It can be sent out as a message through a valid/ready port. It can also be logged into a fixed-size store buffer that either wraps or stops and raises an interrupt when it fills.

A debug-exception input freezes the recent-transfer stack by clearing its enable bit, so that software can read the history leading up to the exception. Software reads the stack and the store buffer through index-addressed read ports. It clears a stopped store buffer with a one-cycle clear strobe. While a message waits for an accepting consumer, the block signals busy to the core, and events presented during that time are not accepted.

Top module: `branch_trace_unit`

## Requirements
- R1: After reset the control register reads zero, the stack pointer, store write index, store full flag, interrupt and message valid are all zero, and every stack and store entry reads zero.
- R2: A control write stores bits 8..0 of the write data, and a read returns those nine bits with bits 31..9 as zero; bits 5..1 have no effect beyond being stored.
- R3: With control bit 0 set, each accepted record {source, target} is written to stack slot (pointer+1) mod 8, and the pointer advances to that slot; the read port returns the slot selected by the index.
- R4: An event is accepted when event-valid is high, busy is low and the kind is not 0; kind encoding is 0 not-taken branch, 1 taken branch, 2 interrupt, 3 exception. A kind-0 event changes neither the stack, the message port nor the store buffer.
- R5: A debug-exception pulse clears control bit 0 on the next edge, taking priority over a same-cycle control write; an event in the same cycle is not pushed, and the stack then holds its content.
- R6: With control bit 6 set, each accepted event loads source, target and kind into the message port and raises message valid on the next edge; while valid is high and ready is low, the message holds and busy is high.
- R7: With control bit 7 set, each accepted record is written to store slot at the write index, the index advances mod 16, and the full flag sets when slot 15 is written.
- R8: With control bit 8 clear, logging continues past full, wrapping the index to 0 and overwriting the oldest entries.
- R9: With control bit 8 set, no write happens while full is high, the interrupt output equals full AND bit 8, and a clear strobe zeroes the write index and the full flag, overriding a same-cycle write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control write data |
| ctl_rdata | output | 32 | Control register read value |
| dbg_exc | input | 1 | Debug exception taken; freezes the stack |
| ev_valid | input | 1 | Event present |
| ev_kind | input | 2 | Event kind (0 not-taken, 1 taken, 2 interrupt, 3 exception) |
| ev_from | input | 32 | Source address |
| ev_to | input | 32 | Target address |
| ev_busy | output | 1 | Events are not accepted this cycle |
| lbr_idx | input | 3 | Stack read index |
| lbr_from | output | 32 | Source address of selected stack slot |
| lbr_to | output | 32 | Target address of selected stack slot |
| lbr_tos | output | 3 | Stack top pointer |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message consumer ready |
| msg_from | output | 32 | Message source address |
| msg_to | output | 32 | Message target address |
| msg_kind | output | 2 | Message event kind |
| st_idx | input | 4 | Store buffer read index |
| st_from | output | 32 | Source address of selected store slot |
| st_to | output | 32 | Target address of selected store slot |
| st_wptr | output | 4 | Store write index |
| st_full | output | 1 | Store buffer full flag |
| st_clr | input | 1 | Clear store index and full flag |
| irq | output | 1 | Store-full interrupt |

## Verification
Events of all four kinds are mixed in one stream, so a design that records a not-taken branch or drops an interrupt diverges from the reference. Runs longer than the stack and the buffer show the difference between wrapping and stopping. A debug-exception pulse that coincides with an event tells apart freezing before and after the push. A message phase with ready held low while further events arrive separates holding the message from overwriting it. It also shows whether the events blocked during busy are dropped everywhere rather than being recorded in only some of the destinations.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int ADDR_W = 32;
  localparam int CTL_W  = 9;
  localparam int CB_REC  = 0;
  localparam int CB_MSG  = 6;
  localparam int CB_LOG  = 7;
  localparam int CB_STOP = 8;

  typedef enum logic [1:0] {
    EV_NOTTAKEN = 2'd0,
    EV_TAKEN    = 2'd1,
    EV_INTR     = 2'd2,
    EV_EXC      = 2'd3
  } ev_kind_e;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
  } rec_t;
endpackage

// File: rtl/bt_ctl_reg.sv
module bt_ctl_reg
  import bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic             dbg_exc,
  output logic [CTL_W-1:0] ctl_q
);
  logic [CTL_W-1:0] ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (we) ctl_d = wdata;
    if (dbg_exc) ctl_d[CB_REC] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  AST_DBG_CLEARS_REC: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_exc |=> !ctl_q[CB_REC]); // R5
endmodule

// File: rtl/bt_lbr_stack.sv
module bt_lbr_stack
  import bt_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  rec_t                     rec,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output rec_t                     rd_rec,
  output logic [$clog2(DEPTH)-1:0] tos_q
);
  localparam int PW = $clog2(DEPTH);

  logic [PW-1:0] tos_nxt;
  logic [PW-1:0] tos_d;
  rec_t          mem_q [DEPTH];

  always_comb begin
    tos_nxt = (tos_q == PW'(DEPTH-1)) ? '0 : tos_q + 1'b1;
    tos_d   = push ? tos_nxt : tos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tos_q <= '0;
    else        tos_q <= tos_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_we;
    assign slot_we = push && (tos_nxt == PW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[i] <= '0;
      else if (slot_we) mem_q[i] <= rec;
    end
  end

  assign rd_rec = mem_q[rd_idx];

  AST_TOS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    push && (tos_q != PW'(DEPTH-1)) |=> tos_q == PW'($past(tos_q) + 1'b1)); // R3
  AST_TOS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> $stable(tos_q)); // R5
endmodule

// File: rtl/bt_msg_port.sv
module bt_msg_port
  import bt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  rec_t       rec,
  input  logic [1:0] kind,
  input  logic       ready,
  output logic       valid_q,
  output rec_t       msg_q,
  output logic [1:0] kind_q,
  output logic       busy
);
  logic       valid_d;
  rec_t       msg_d;
  logic [1:0] kind_d;

  assign busy = valid_q && !ready;

  always_comb begin
    valid_d = valid_q;
    msg_d   = msg_q;
    kind_d  = kind_q;
    if (load) begin
      valid_d = 1'b1;
      msg_d   = rec;
      kind_d  = kind;
    end else if (ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      msg_q   <= '0;
      kind_q  <= '0;
    end else begin
      valid_q <= valid_d;
      msg_q   <= msg_d;
      kind_q  <= kind_d;
    end
  end

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !ready |=> valid_q && $stable(msg_q) && $stable(kind_q)); // R6
endmodule

// File: rtl/bt_store_buf.sv
module bt_store_buf
  import bt_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     log_en,
  input  logic                     stop_mode,
  input  logic                     clr,
  input  rec_t                     rec,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output rec_t                     rd_rec,
  output logic [$clog2(DEPTH)-1:0] wptr_q,
  output logic                     full_q
);
  localparam int PW = $clog2(DEPTH);

  logic          wr;
  logic [PW-1:0] wptr_d;
  logic          full_d;
  rec_t          mem_q [DEPTH];

  always_comb begin
    wr     = log_en && !(full_q && stop_mode) && !clr;
    wptr_d = wptr_q;
    full_d = full_q;
    if (clr) begin
      wptr_d = '0;
      full_d = 1'b0;
    end else if (wr) begin
      wptr_d = (wptr_q == PW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
      if (wptr_q == PW'(DEPTH-1)) full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      full_q <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      full_q <= full_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_we;
    assign slot_we = wr && (wptr_q == PW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[i] <= '0;
      else if (slot_we) mem_q[i] <= rec;
    end
  end

  assign rd_rec = mem_q[rd_idx];

  AST_STOP_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && stop_mode && !clr |=> $stable(wptr_q) && full_q); // R9
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (wptr_q == '0) && !full_q); // R9
  AST_FULL_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    log_en && !clr && !full_q && (wptr_q == PW'(DEPTH-1)) |=> full_q); // R7
endmodule

// File: rtl/branch_trace_unit.sv
module branch_trace_unit
  import bt_pkg::*;
#(
  parameter int LBR_DEPTH = 8,
  parameter int ST_DEPTH  = 16,
  localparam int LW = $clog2(LBR_DEPTH),
  localparam int SW = $clog2(ST_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [31:0]       ctl_wdata,
  output logic [31:0]       ctl_rdata,
  input  logic              dbg_exc,
  input  logic              ev_valid,
  input  logic [1:0]        ev_kind,
  input  logic [ADDR_W-1:0] ev_from,
  input  logic [ADDR_W-1:0] ev_to,
  output logic              ev_busy,
  input  logic [LW-1:0]     lbr_idx,
  output logic [ADDR_W-1:0] lbr_from,
  output logic [ADDR_W-1:0] lbr_to,
  output logic [LW-1:0]     lbr_tos,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [ADDR_W-1:0] msg_from,
  output logic [ADDR_W-1:0] msg_to,
  output logic [1:0]        msg_kind,
  input  logic [SW-1:0]     st_idx,
  output logic [ADDR_W-1:0] st_from,
  output logic [ADDR_W-1:0] st_to,
  output logic [SW-1:0]     st_wptr,
  output logic              st_full,
  input  logic              st_clr,
  output logic              irq
);
  logic [1:0]       rs_q;
  logic             rst_i_n;
  logic [CTL_W-1:0] ctl_q;
  logic             accept;
  logic             push;
  logic             load;
  logic             log_en;
  rec_t             ev_rec;
  rec_t             lbr_rec;
  rec_t             msg_rec;
  rec_t             st_rec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  always_comb begin
    ev_rec.src = ev_from;
    ev_rec.dst = ev_to;
    accept = ev_valid && !ev_busy && (ev_kind != EV_NOTTAKEN);
    push   = accept && ctl_q[CB_REC] && !dbg_exc;
    load   = accept && ctl_q[CB_MSG];
    log_en = accept && ctl_q[CB_LOG];
  end

  bt_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_i_n), .we(ctl_we), .wdata(ctl_wdata[CTL_W-1:0]),
    .dbg_exc(dbg_exc), .ctl_q(ctl_q)
  );

  bt_lbr_stack #(.DEPTH(LBR_DEPTH)) u_lbr (
    .clk(clk), .rst_n(rst_i_n), .push(push), .rec(ev_rec),
    .rd_idx(lbr_idx), .rd_rec(lbr_rec), .tos_q(lbr_tos)
  );

  bt_msg_port u_msg (
    .clk(clk), .rst_n(rst_i_n), .load(load), .rec(ev_rec), .kind(ev_kind),
    .ready(msg_ready), .valid_q(msg_valid), .msg_q(msg_rec), .kind_q(msg_kind),
    .busy(ev_busy)
  );

  bt_store_buf #(.DEPTH(ST_DEPTH)) u_st (
    .clk(clk), .rst_n(rst_i_n), .log_en(log_en), .stop_mode(ctl_q[CB_STOP]),
    .clr(st_clr), .rec(ev_rec), .rd_idx(st_idx), .rd_rec(st_rec),
    .wptr_q(st_wptr), .full_q(st_full)
  );

  assign ctl_rdata = {{(32-CTL_W){1'b0}}, ctl_q};
  assign lbr_from  = lbr_rec.src;
  assign lbr_to    = lbr_rec.dst;
  assign msg_from  = msg_rec.src;
  assign msg_to    = msg_rec.dst;
  assign st_from   = st_rec.src;
  assign st_to     = st_rec.dst;
  assign irq       = st_full && ctl_q[CB_STOP];

  AST_NOTTAKEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_i_n)
    ev_valid && (ev_kind == EV_NOTTAKEN) && !st_clr |=> $stable(lbr_tos) && $stable(st_wptr)); // R4
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_i_n)
    ev_busy && !st_clr |=> $stable(lbr_tos) && $stable(st_wptr)); // R6
endmodule

// File: tb/test_branch_trace_unit.sv
module test_branch_trace_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata;
  logic        dbg_exc = 1'b0;
  logic        ev_valid = 1'b0;
  logic [1:0]  ev_kind = '0;
  logic [31:0] ev_from = '0;
  logic [31:0] ev_to = '0;
  logic        ev_busy;
  logic [2:0]  lbr_idx = '0;
  logic [31:0] lbr_from, lbr_to;
  logic [2:0]  lbr_tos;
  logic        msg_valid;
  logic        msg_ready = 1'b1;
  logic [31:0] msg_from, msg_to;
  logic [1:0]  msg_kind;
  logic [3:0]  st_idx = '0;
  logic [31:0] st_from, st_to;
  logic [3:0]  st_wptr;
  logic        st_full;
  logic        st_clr = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  branch_trace_unit i_branch_trace_unit (.*);

  always #10ns clk = ~clk;

  // behavioural reference state
  logic [63:0] m_lbr [8];
  logic [63:0] m_st [16];
  int          m_tos, m_wp;
  logic        m_full, m_mval;
  logic [31:0] m_mfrom, m_mto;
  logic [1:0]  m_mkind;
  logic [8:0]  m_ctl;
  logic        m_acc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_lbr[i]) m_lbr[i] = '0;
      foreach (m_st[i]) m_st[i] = '0;
      m_tos = 0; m_wp = 0; m_full = 0; m_mval = 0;
      m_mfrom = '0; m_mto = '0; m_mkind = '0; m_ctl = '0;
    end else begin
      m_acc = ev_valid && !(m_mval && !msg_ready) && (ev_kind != 2'd0);
      if (m_acc && m_ctl[0] && !dbg_exc) begin
        m_tos = (m_tos + 1) % 8;
        m_lbr[m_tos] = {ev_from, ev_to};
      end
      if (m_acc && m_ctl[6]) begin
        m_mval = 1; m_mfrom = ev_from; m_mto = ev_to; m_mkind = ev_kind;
      end else if (msg_ready) begin
        m_mval = 0;
      end
      if (st_clr) begin
        m_wp = 0; m_full = 0;
      end else if (m_acc && m_ctl[7] && !(m_full && m_ctl[8])) begin
        m_st[m_wp] = {ev_from, ev_to};
        if (m_wp == 15) m_full = 1;
        m_wp = (m_wp + 1) % 16;
      end
      if (ctl_we) m_ctl = ctl_wdata[8:0];
      if (dbg_exc) m_ctl[0] = 1'b0;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(posedge clk) begin
    #5ns;
    check("R2", "ctl_rdata", 64'(ctl_rdata), {55'd0, m_ctl});
    check("R3", "lbr_tos", 64'(lbr_tos), 64'(m_tos));
    check("R3", "lbr_entry", {lbr_from, lbr_to}, m_lbr[lbr_idx]);
    check("R6", "msg_valid", 64'(msg_valid), 64'(m_mval));
    check("R6", "msg_data", {msg_from, msg_to}, {m_mfrom, m_mto});
    check("R6", "msg_kind", 64'(msg_kind), 64'(m_mkind));
    check("R6", "ev_busy", 64'(ev_busy), 64'(m_mval && !msg_ready));
    check("R7", "st_wptr", 64'(st_wptr), 64'(m_wp));
    check("R7", "st_entry", {st_from, st_to}, m_st[st_idx]);
    check("R9", "st_full", 64'(st_full), 64'(m_full));
    check("R9", "irq", 64'(irq), 64'(m_full && m_ctl[8]));
  end

  // sweep the read ports
  always @(negedge clk) begin
    lbr_idx <= lbr_idx + 3'd1;
    st_idx  <= st_idx + 4'd3;
  end

  task automatic wr_ctl(input logic [31:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic send(input logic [1:0] k, input logic [31:0] f, input logic [31:0] t);
    @(negedge clk); ev_valid = 1'b1; ev_kind = k; ev_from = f; ev_to = t;
    @(negedge clk); ev_valid = 1'b0;
  endtask

  task automatic burst(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) send(2'((i % 3) + 1), base + 32'(i * 16), base + 32'(i * 16 + 4));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int saved;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #15ns;
    check("R1", "reset ctl", 64'(ctl_rdata), 64'd0);
    check("R1", "reset tos/wptr/full/irq/msg",
          64'({lbr_tos, st_wptr, st_full, irq, msg_valid}), 64'd0);
    @(negedge clk);

    // R2: reserved bits and storage-only flags
    wr_ctl(32'hFFFF_FFFF);
    wr_ctl(32'h0000_003E);
    burst(3, 32'h1000);
    #15ns; check("R2", "storage-only flags inert", 64'({lbr_tos, st_wptr, msg_valid}), 64'd0);

    // R3 / R4: stack recording with mixed kinds, including not-taken
    wr_ctl(32'h1);
    send(2'd1, 32'hA000, 32'hA100);
    send(2'd2, 32'hA200, 32'hA300);
    @(negedge clk); saved = int'(lbr_tos);
    send(2'd0, 32'hDEAD, 32'hBEEF);
    #15ns; check("R4", "not-taken no push", 64'(lbr_tos), 64'(saved));
    send(2'd3, 32'hA400, 32'hA500);
    burst(9, 32'hB000);

    // R5: debug exception coincident with an event
    @(negedge clk); saved = int'(lbr_tos);
    ev_valid = 1'b1; ev_kind = 2'd1; ev_from = 32'hC000; ev_to = 32'hC004; dbg_exc = 1'b1;
    @(negedge clk); ev_valid = 1'b0; dbg_exc = 1'b0;
    burst(4, 32'hC100);
    #15ns;
    check("R5", "stack frozen", 64'(lbr_tos), 64'(saved));
    check("R5", "bit0 cleared", 64'(ctl_rdata[0]), 64'd0);
    // dbg_exc wins over a same-cycle write of bit 0
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = 32'h1; dbg_exc = 1'b1;
    @(negedge clk); ctl_we = 1'b0; dbg_exc = 1'b0;

    // R6: message port with back-pressure
    wr_ctl(32'h41);
    msg_ready = 1'b0;
    send(2'd2, 32'hD000, 32'hD004);
    burst(3, 32'hD100);
    #15ns; check("R6", "held message", 64'({msg_valid, msg_from}), {31'd0, 1'b1, 32'hD000});
    @(negedge clk); msg_ready = 1'b1;
    burst(4, 32'hD200);

    // R7 / R8: wrap-mode logging
    wr_ctl(32'h80);
    burst(20, 32'hE000);
    #15ns; check("R8", "wrapped index/full", 64'({st_wptr, st_full}), {59'd0, 4'd4, 1'b1});
    check("R9", "no irq in wrap mode", 64'(irq), 64'd0);
    @(negedge clk); st_clr = 1'b1;
    @(negedge clk); st_clr = 1'b0;

    // R9: stop mode with interrupt, then clear against a concurrent event
    wr_ctl(32'h180);
    burst(19, 32'hF000);
    #15ns; check("R9", "stopped at full", 64'({st_wptr, st_full, irq}), {58'd0, 4'd0, 2'b11});
    @(negedge clk); st_clr = 1'b1; ev_valid = 1'b1; ev_kind = 2'd3; ev_from = 32'h5; ev_to = 32'h6;
    @(negedge clk); st_clr = 1'b0; ev_valid = 1'b0;
    #15ns; check("R9", "clear wins", 64'({st_wptr, st_full, irq}), 64'd0);
    burst(2, 32'h9000);
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule